// File: doc/BRIEF.md
# Genetic Recombination Stage (Crossover and Mutation)

This block is the reproduction step of a hardware genetic-algorithm engine. It takes one pair of parent chromosomes per clock and returns two offspring. The offspring are first recombined by crossover and then altered by mutation. Crossover can run in uniform, single-cut or double-cut form. Mutation can run in per-bit or single-bit form. Each operator fires with a probability of k/128, where k is a rate code from 0 to 128. The chromosome is either 16 or 32 bits wide, and any bit above the active width is cleared in the results.

The block holds no random generator of its own. An external source supplies a wide random word `rnd_i` beside each parent pair. All random fields for both operators are taken from that word in the same cycle as the parents, so a given offspring pair depends only on the inputs of one cycle. The result appears two cycles later with its own valid flag. A new pair can be accepted every cycle.

Top module: `gxm_recombine`

## Requirements
- R1: Each cycle with `in_valid_i`=1 produces exactly one cycle with `out_valid_o`=1, two clock edges later. Back-to-back inputs give back-to-back results in the same order.
- R2: With `len_full_i`=0 the active width is 16. Result bits 31..16 are 0, and parent bits 31..16 have no effect on the result. With `len_full_i`=1 the active width is 32.
- R3: Crossover fires only when the 7-bit gate `rnd_i[6:0]`, read as unsigned, is less than `xo_rate_i`. A rate of 0 never fires, and a rate of 128 or above always fires. When crossover does not fire, each child equals its own parent within the active width.
- R4: Mode `xo_mode_i`=0 (uniform): the swap mask is `rnd_i[38:7]`. Bit i of the two parents is exchanged wherever mask bit i is 1.
- R5: Mode 1 (single cut): the cut is c = `rnd_i[43:39]` modulo the active width. Every bit at position c or above is exchanged.
- R6: Mode 2 (double cut): the second cut is `rnd_i[48:44]`, and both cuts are taken modulo the active width. With lo the smaller cut and hi the larger, bits with lo <= i < hi are exchanged. Equal cuts exchange nothing.
- R7: Mode 3 never exchanges bits, whatever the rate.
- R8: `mu_mode_i`=1 (single bit): child A flips bit (`rnd_i[53:49]` mod width) when its lane-0 value is below `mu_rate_i`. Child B does the same with `rnd_i[58:54]`. All other bits are unchanged.
- R9: `mu_mode_i`=0 (per bit): child A bit i flips when the 7-bit lane `rnd_i[59+7i +: 7]` is below `mu_rate_i`. Child B uses `rnd_i[283+7i +: 7]`. Only bits inside the active width can flip. Lane 0 of each child is also the gate used in R8.
- R10: A mutation rate of 0 leaves both crossover children unchanged in either mutation mode.
- R11: While `rst_n` is low, `out_valid_o` is 0 and both results are 0. Pairs already in flight when reset is asserted are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Parent pair and random word are valid this cycle |
| par_a_i | input | 32 | Parent A chromosome |
| par_b_i | input | 32 | Parent B chromosome |
| len_full_i | input | 1 | 1 = 32-bit chromosome, 0 = 16-bit |
| xo_mode_i | input | 2 | Crossover form: 0 uniform, 1 single cut, 2 double cut, 3 none |
| xo_rate_i | input | 8 | Crossover rate code k (probability k/128) |
| mu_mode_i | input | 1 | Mutation form: 0 per bit, 1 single bit |
| mu_rate_i | input | 8 | Mutation rate code k (probability k/128) |
| rnd_i | input | 507 | Random fields for both operators, laid out as in R3 to R9 |
| out_valid_o | output | 1 | Offspring valid |
| kid_a_o | output | 32 | Offspring derived from parent A |
| kid_b_o | output | 32 | Offspring derived from parent B |

## Verification
Crossover is registered at the first edge after the parents are accepted, and mutation is registered at the second, so every offspring pair is due exactly two edges after its input cycle. The bench stamps each accepted vector with the cycle count at which it was driven and compares the result only when `out_valid_o` is seen on the falling edge of that due cycle. A result at any other cycle fails as a latency error. Vectors are driven back to back so that pipeline ordering is checked as well.

// File: rtl/gxm_pkg.sv
package gxm_pkg;
  localparam int GATE_W = 7;
  localparam int RATE_W = 8;

  typedef enum logic [1:0] {
    XO_UNI  = 2'd0,
    XO_ONE  = 2'd1,
    XO_TWO  = 2'd2,
    XO_NONE = 2'd3
  } xo_mode_e;

  typedef enum logic {
    MU_UNI = 1'b0,
    MU_ONE = 1'b1
  } mu_mode_e;

  // operator fires when the random gate lies below the rate code
  function automatic logic rate_hit(input logic [GATE_W-1:0] g,
                                    input logic [RATE_W-1:0] k);
    return {1'b0, g} < k;
  endfunction
endpackage

// File: rtl/gxm_xover.sv
module gxm_xover
  import gxm_pkg::*;
#(
  parameter int W = 32,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]      par_a,
  input  logic [W-1:0]      par_b,
  input  logic [W-1:0]      lmask,
  input  logic              len_full,
  input  logic [1:0]        mode,
  input  logic [RATE_W-1:0] rate,
  input  logic [GATE_W-1:0] gate,
  input  logic [W-1:0]      rmask,
  input  logic [CW-1:0]     cut_a,
  input  logic [CW-1:0]     cut_b,
  output logic [W-1:0]      kid_a,
  output logic [W-1:0]      kid_b,
  output logic              fired
);
  function automatic logic [CW-1:0] wrap_cut(input logic [CW-1:0] c,
                                             input logic full);
    return full ? c : {1'b0, c[CW-2:0]};
  endfunction

  function automatic logic [W-1:0] from_pos(input logic [CW-1:0] c);
    return {W{1'b1}} << c;
  endfunction

  logic [CW-1:0] ca_w, cb_w, lo_w, hi_w;
  logic [W-1:0]  sel, swap;

  always_comb begin
    ca_w = wrap_cut(cut_a, len_full);
    cb_w = wrap_cut(cut_b, len_full);
    lo_w = (ca_w < cb_w) ? ca_w : cb_w;
    hi_w = (ca_w < cb_w) ? cb_w : ca_w;
    unique case (xo_mode_e'(mode))
      XO_UNI:  sel = rmask;
      XO_ONE:  sel = from_pos(ca_w);
      XO_TWO:  sel = from_pos(lo_w) & ~from_pos(hi_w);
      default: sel = '0;
    endcase
    fired = (xo_mode_e'(mode) != XO_NONE) && rate_hit(gate, rate);
    swap  = fired ? (sel & lmask) : '0;
    kid_a = ((par_a & ~swap) | (par_b & swap)) & lmask;
    kid_b = ((par_b & ~swap) | (par_a & swap)) & lmask;
  end
endmodule

// File: rtl/gxm_mutate.sv
module gxm_mutate
  import gxm_pkg::*;
#(
  parameter int W = 32,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]        kid,
  input  logic [W-1:0]        lmask,
  input  logic                len_full,
  input  logic                mode,
  input  logic [RATE_W-1:0]   rate,
  input  logic [CW-1:0]       pos,
  input  logic [W*GATE_W-1:0] lanes,
  output logic [W-1:0]        mutd,
  output logic [W-1:0]        flips
);
  logic [W-1:0]  per_bit;
  logic [CW-1:0] pos_w;

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign per_bit[i] = rate_hit(lanes[i*GATE_W +: GATE_W], rate);
  end

  always_comb begin
    pos_w = len_full ? pos : {1'b0, pos[CW-2:0]};
    if (mu_mode_e'(mode) == MU_ONE)
      flips = rate_hit(lanes[GATE_W-1:0], rate) ? (W'(1) << pos_w) : '0;
    else
      flips = per_bit;
    flips = flips & lmask;
    mutd  = kid ^ flips;
  end
endmodule

// File: rtl/gxm_recombine.sv
module gxm_recombine
  import gxm_pkg::*;
#(
  parameter int W = 32,
  localparam int CW    = $clog2(W),
  localparam int LANES = W * GATE_W,
  localparam int MK_LO = GATE_W,
  localparam int CA_LO = MK_LO + W,
  localparam int CB_LO = CA_LO + CW,
  localparam int PA_LO = CB_LO + CW,
  localparam int PB_LO = PA_LO + CW,
  localparam int LA_LO = PB_LO + CW,
  localparam int LB_LO = LA_LO + LANES,
  localparam int RND_W = LB_LO + LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [W-1:0]      par_a_i,
  input  logic [W-1:0]      par_b_i,
  input  logic              len_full_i,
  input  logic [1:0]        xo_mode_i,
  input  logic [RATE_W-1:0] xo_rate_i,
  input  logic              mu_mode_i,
  input  logic [RATE_W-1:0] mu_rate_i,
  input  logic [RND_W-1:0]  rnd_i,
  output logic              out_valid_o,
  output logic [W-1:0]      kid_a_o,
  output logic [W-1:0]      kid_b_o
);
  localparam logic [W-1:0] HALF_MASK = {{(W/2){1'b0}}, {(W/2){1'b1}}};

  logic [W-1:0] lmask_in, xo_a, xo_b;
  logic         xo_fired;

  assign lmask_in = len_full_i ? '1 : HALF_MASK;

  gxm_xover #(.W(W)) u_xover (
    .par_a    (par_a_i),
    .par_b    (par_b_i),
    .lmask    (lmask_in),
    .len_full (len_full_i),
    .mode     (xo_mode_i),
    .rate     (xo_rate_i),
    .gate     (rnd_i[GATE_W-1:0]),
    .rmask    (rnd_i[MK_LO +: W]),
    .cut_a    (rnd_i[CA_LO +: CW]),
    .cut_b    (rnd_i[CB_LO +: CW]),
    .kid_a    (xo_a),
    .kid_b    (xo_b),
    .fired    (xo_fired)
  );

  // stage 1: crossover result plus everything mutation still needs
  logic              s1_vld, s1_len, s1_mm;
  logic [W-1:0]      s1_a, s1_b;
  logic [RATE_W-1:0] s1_mr;
  logic [CW-1:0]     s1_pa, s1_pb;
  logic [LANES-1:0]  s1_la, s1_lb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_len <= 1'b0;
      s1_mm  <= 1'b0;
      s1_a   <= '0;
      s1_b   <= '0;
      s1_mr  <= '0;
      s1_pa  <= '0;
      s1_pb  <= '0;
      s1_la  <= '0;
      s1_lb  <= '0;
    end else begin
      s1_vld <= in_valid_i;
      if (in_valid_i) begin
        s1_len <= len_full_i;
        s1_mm  <= mu_mode_i;
        s1_a   <= xo_a;
        s1_b   <= xo_b;
        s1_mr  <= mu_rate_i;
        s1_pa  <= rnd_i[PA_LO +: CW];
        s1_pb  <= rnd_i[PB_LO +: CW];
        s1_la  <= rnd_i[LA_LO +: LANES];
        s1_lb  <= rnd_i[LB_LO +: LANES];
      end
    end
  end

  logic [W-1:0] s1_lmask, mu_a, mu_b, flip_a, flip_b;
  assign s1_lmask = s1_len ? '1 : HALF_MASK;

  gxm_mutate #(.W(W)) u_mut_a (
    .kid      (s1_a),
    .lmask    (s1_lmask),
    .len_full (s1_len),
    .mode     (s1_mm),
    .rate     (s1_mr),
    .pos      (s1_pa),
    .lanes    (s1_la),
    .mutd     (mu_a),
    .flips    (flip_a)
  );

  gxm_mutate #(.W(W)) u_mut_b (
    .kid      (s1_b),
    .lmask    (s1_lmask),
    .len_full (s1_len),
    .mode     (s1_mm),
    .rate     (s1_mr),
    .pos      (s1_pb),
    .lanes    (s1_lb),
    .mutd     (mu_b),
    .flips    (flip_b)
  );

  // stage 2: mutated offspring
  logic len_q2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      kid_a_o     <= '0;
      kid_b_o     <= '0;
      len_q2      <= 1'b0;
    end else begin
      out_valid_o <= s1_vld;
      if (s1_vld) begin
        kid_a_o <= mu_a;
        kid_b_o <= mu_b;
        len_q2  <= s1_len;
      end
    end
  end
endmodule

// File: rtl/gxm_checker.sv
module gxm_checker
  import gxm_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid_i,
  input logic [W-1:0]      par_a_i,
  input logic [W-1:0]      par_b_i,
  input logic              len_full_i,
  input logic [RATE_W-1:0] xo_rate_i,
  input logic              s1_vld,
  input logic [W-1:0]      s1_a,
  input logic [W-1:0]      s1_b,
  input logic              s1_mm,
  input logic [RATE_W-1:0] s1_mr,
  input logic              len_q2,
  input logic              out_valid_o,
  input logic [W-1:0]      kid_a_o,
  input logic [W-1:0]      kid_b_o
);
  logic [W-1:0] act_mask;
  assign act_mask = len_full_i ? '1 : {{(W/2){1'b0}}, {(W/2){1'b1}}};

  // R1: valid travels through both stages, one edge each
  p_stage1_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> s1_vld);
  p_stage1_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> !s1_vld);
  p_stage2_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> out_valid_o);

  // R2: nothing above a 16-bit chromosome
  p_upper_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !len_q2) |-> (kid_a_o[W-1:W/2] == '0 && kid_b_o[W-1:W/2] == '0));

  // R3: a zero rate leaves the parents in place
  p_no_xover_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && xo_rate_i == '0) |=>
      (s1_a == $past(par_a_i & act_mask) && s1_b == $past(par_b_i & act_mask)));

  // R4: exchanging bits keeps the pairwise difference of the parents
  p_swap_keeps_diff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> ((s1_a ^ s1_b) == $past((par_a_i ^ par_b_i) & act_mask)));

  // R8: single-bit mutation changes at most one bit per child
  p_single_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_mm == 1'b1) |=>
      ($countones(kid_a_o ^ $past(s1_a)) <= 1 && $countones(kid_b_o ^ $past(s1_b)) <= 1));

  // R10: zero mutation rate passes crossover output through
  p_no_mutation_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_mr == '0) |=> (kid_a_o == $past(s1_a) && kid_b_o == $past(s1_b)));
endmodule

bind gxm_recombine gxm_checker #(.W(W)) u_gxm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid_i  (in_valid_i),
  .par_a_i     (par_a_i),
  .par_b_i     (par_b_i),
  .len_full_i  (len_full_i),
  .xo_rate_i   (xo_rate_i),
  .s1_vld      (s1_vld),
  .s1_a        (s1_a),
  .s1_b        (s1_b),
  .s1_mm       (s1_mm),
  .s1_mr       (s1_mr),
  .len_q2      (len_q2),
  .out_valid_o (out_valid_o),
  .kid_a_o     (kid_a_o),
  .kid_b_o     (kid_b_o)
);

// File: tb/test_gxm_recombine.sv
module test_gxm_recombine;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  typedef struct packed {
    logic [7:0]  req;
    logic [31:0] pa, pb;
    logic        len;
    logic [1:0]  xm;
    logic [7:0]  xr;
    logic [6:0]  gate;
    logic [31:0] mask;
    logic [4:0]  c1, c2;
    logic        mm;
    logic [7:0]  mr;
    logic [4:0]  qa, qb;
    logic [31:0] fa, fb;
  } vec_t;

  // req, pa, pb, len, xm, xr, gate, mask, c1, c2, mm, mr, qa, qb, fa, fb
  localparam vec_t TBL [NV] = '{
    '{8'd4, 32'hAAAA5555, 32'h12345678, 1'b1, 2'd0, 8'd128, 7'd127, 32'h0F0F00FF, 5'd0, 5'd0, 1'b0, 8'd0, 5'd0, 5'd0, 32'h0, 32'h0},      // R4
    '{8'd3, 32'hDEADBEEF, 32'h01234567, 1'b1, 2'd0, 8'd0, 7'd0, 32'hFFFFFFFF, 5'd0, 5'd0, 1'b0, 8'd0, 5'd0, 5'd0, 32'h0, 32'h0},         // R3
    '{8'd5, 32'hFFFFFFFF, 32'h00000000, 1'b1, 2'd1, 8'd128, 7'd5, 32'h0, 5'd12, 5'd0, 1'b0, 8'd0, 5'd0, 5'd0, 32'h0, 32'h0},            // R5
    '{8'd6, 32'hFFFFFFFF, 32'h00000000, 1'b1, 2'd2, 8'd128, 7'd5, 32'h0, 5'd20, 5'd4, 1'b0, 8'd0, 5'd0, 5'd0, 32'h0, 32'h0},            // R6
    '{8'd6, 32'hF0F0F0F0, 32'h0F0F0F0F, 1'b1, 2'd2, 8'd128, 7'd5, 32'h0, 5'd9, 5'd9, 1'b0, 8'd0, 5'd0, 5'd0, 32'h0, 32'h0},             // R6
    '{8'd2, 32'hFFFF00FF, 32'hABCDFF00, 1'b0, 2'd1, 8'd128, 7'd1, 32'h0, 5'd21, 5'd0, 1'b0, 8'd0, 5'd0, 5'd0, 32'h0, 32'h0},            // R2, R5
    '{8'd7, 32'h11112222, 32'h33334444, 1'b1, 2'd3, 8'd128, 7'd0, 32'hFFFFFFFF, 5'd3, 5'd7, 1'b0, 8'd0, 5'd0, 5'd0, 32'h0, 32'h0},      // R7
    '{8'd3, 32'hFFFFFFFF, 32'h00000000, 1'b1, 2'd0, 8'd100, 7'd100, 32'hFFFFFFFF, 5'd0, 5'd0, 1'b0, 8'd0, 5'd0, 5'd0, 32'h0, 32'h0},   // R3
    '{8'd3, 32'hFFFFFFFF, 32'h00000000, 1'b1, 2'd0, 8'd100, 7'd99, 32'h0000FFFF, 5'd0, 5'd0, 1'b0, 8'd0, 5'd0, 5'd0, 32'h0, 32'h0},    // R3
    '{8'd8, 32'h00000000, 32'hFFFFFFFF, 1'b1, 2'd3, 8'd0, 7'd0, 32'h0, 5'd0, 5'd0, 1'b1, 8'd1, 5'd31, 5'd3, 32'h00000001, 32'h00000001}, // R8
    '{8'd8, 32'h00001234, 32'h0000FFFF, 1'b0, 2'd3, 8'd0, 7'd0, 32'h0, 5'd0, 5'd0, 1'b1, 8'd64, 5'd20, 5'd15, 32'h00000001, 32'h0},   // R8
    '{8'd9, 32'h00000000, 32'hFFFFFFFF, 1'b1, 2'd3, 8'd0, 7'd0, 32'h0, 5'd0, 5'd0, 1'b0, 8'd64, 5'd0, 5'd0, 32'hC3A50F81, 32'h13572468}, // R9
    '{8'd10, 32'h9ABCDEF0, 32'h0F1E2D3C, 1'b1, 2'd3, 8'd0, 7'd0, 32'h0, 5'd0, 5'd0, 1'b0, 8'd0, 5'd0, 5'd0, 32'hFFFFFFFF, 32'hFFFFFFFF}, // R10
    '{8'd9, 32'hFFFF0000, 32'h0000FFFF, 1'b0, 2'd3, 8'd0, 7'd0, 32'h0, 5'd0, 5'd0, 1'b0, 8'd255, 5'd0, 5'd0, 32'h0, 32'h0},          // R9
    '{8'd2, 32'hFFFFFFFF, 32'h00000000, 1'b0, 2'd2, 8'd255, 7'd126, 32'h0, 5'd30, 5'd3, 1'b0, 8'd0, 5'd0, 5'd0, 32'h0, 32'h0}        // R2, R6
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid_i = 1'b0;
  logic [31:0]  par_a_i = '0, par_b_i = '0;
  logic         len_full_i = 1'b0;
  logic [1:0]   xo_mode_i = '0;
  logic [7:0]   xo_rate_i = '0;
  logic         mu_mode_i = 1'b0;
  logic [7:0]   mu_rate_i = '0;
  logic [506:0] rnd_i = '0;
  logic         out_valid_o;
  logic [31:0]  kid_a_o, kid_b_o;

  gxm_recombine i_gxm_recombine (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i),
    .par_a_i(par_a_i), .par_b_i(par_b_i), .len_full_i(len_full_i),
    .xo_mode_i(xo_mode_i), .xo_rate_i(xo_rate_i),
    .mu_mode_i(mu_mode_i), .mu_rate_i(mu_rate_i), .rnd_i(rnd_i),
    .out_valid_o(out_valid_o), .kid_a_o(kid_a_o), .kid_b_o(kid_b_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, sent = 0, rcvd = 0;
  bit done = 1'b0;
  logic [31:0] exp_a [NV], exp_b [NV];
  int due [NV];
  int tag [NV];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [506:0] mk_rnd(input vec_t v);
    logic [506:0] r = '0;
    r[6:0]   = v.gate;
    r[38:7]  = v.mask;
    r[43:39] = v.c1;
    r[48:44] = v.c2;
    r[53:49] = v.qa;
    r[58:54] = v.qb;
    for (int i = 0; i < 32; i++) begin
      r[59 + 7*i +: 7]  = v.fa[i] ? 7'd0 : 7'd127;
      r[283 + 7*i +: 7] = v.fb[i] ? 7'd0 : 7'd127;
    end
    return r;
  endfunction

  // bit-serial restatement of the requirements
  function automatic logic [63:0] model(input vec_t v);
    int lim = v.len ? 32 : 16;
    logic [31:0] a = '0, b = '0;
    int k1 = v.c1 % lim, k2 = v.c2 % lim;
    int lo = (k1 < k2) ? k1 : k2, hi = (k1 < k2) ? k2 : k1;
    bit go = (v.xm != 2'd3) && (int'(v.gate) < int'(v.xr));
    for (int i = 0; i < lim; i++) begin
      bit sw = 1'b0;
      if (go) begin
        if (v.xm == 2'd0) sw = v.mask[i];
        else if (v.xm == 2'd1) sw = (i >= k1);
        else sw = (i >= lo) && (i < hi);
      end
      a[i] = sw ? v.pb[i] : v.pa[i];
      b[i] = sw ? v.pa[i] : v.pb[i];
    end
    if (v.mm) begin
      if ((v.fa[0] ? 0 : 127) < int'(v.mr)) a[v.qa % lim] = ~a[v.qa % lim];
      if ((v.fb[0] ? 0 : 127) < int'(v.mr)) b[v.qb % lim] = ~b[v.qb % lim];
    end else begin
      for (int i = 0; i < lim; i++) begin
        if ((v.fa[i] ? 0 : 127) < int'(v.mr)) a[i] = ~a[i];
        if ((v.fb[i] ? 0 : 127) < int'(v.mr)) b[i] = ~b[i];
      end
    end
    return {a, b};
  endfunction

  // result collector: every result must land on its due cycle (R1)
  always @(negedge clk) begin
    if (rst_n && out_valid_o) begin
      if (rcvd >= sent) begin
        check("R1 unexpected valid", {63'd0, out_valid_o}, 64'd0);
      end else begin
        check("R1 latency", 64'(cyc), 64'(due[rcvd]));
        check($sformatf("R%0d offspring", tag[rcvd]), {kid_a_o, kid_b_o},
              {exp_a[rcvd], exp_b[rcvd]});
        rcvd++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset valid", {63'd0, out_valid_o}, 64'd0);
    check("R11 reset outputs", {kid_a_o, kid_b_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      vec_t v = TBL[n];
      logic [63:0] e = model(v);
      par_a_i = v.pa; par_b_i = v.pb; len_full_i = v.len;
      xo_mode_i = v.xm; xo_rate_i = v.xr; mu_mode_i = v.mm; mu_rate_i = v.mr;
      rnd_i = mk_rnd(v);
      in_valid_i = 1'b1;
      exp_a[n] = e[63:32]; exp_b[n] = e[31:0];
      tag[n] = int'(v.req);
      due[n] = cyc + 2;
      sent++;
      @(negedge clk);
    end
    in_valid_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 all results returned", 64'(rcvd), 64'(sent));

    // R11: reset while a pair is in flight drops it
    par_a_i = 32'h5A5A5A5A; par_b_i = 32'hA5A5A5A5; in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R11 in-flight reset valid", {63'd0, out_valid_o}, 64'd0);
    check("R11 in-flight reset outputs", {kid_a_o, kid_b_o}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 no stale result", 64'(rcvd), 64'(sent));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule